// File: doc/BRIEF.md
# Run-Merging Streaming Histogram

The block counts how often each bin index appears in a stream of samples. It accepts one sample on every clock cycle and keeps the bin counts in an internal synchronous RAM. A counter for the current run of equal indices sits in a register. The RAM is touched only when the index changes. At that moment the finished run is written back to the old bin, and the stored count of the new bin is read. These are always two different addresses, so a single write port and a single read port keep up with the stream.

The usual sequence has three steps. First, a clear request zeroes every bin, one bin per cycle. Second, a frame of samples is streamed in, and the final sample is marked with a last flag. Third, once the done pulse appears, the counts are read back through a read port with one cycle of latency. If a second frame is sent without a clear, its counts are added to the counts already stored.

Top module: `hist_run_engine`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy` and `done` are 0.
- R2: A `clearReq` sampled while the block is idle raises `busy` for exactly 2^BIN_W cycles. After that every bin reads back as 0. A `clearReq` that arrives during a frame is ignored.
- R3: Samples presented while `busy` is 1 are ignored: they change no bin and produce no `done`.
- R4: When the block is not busy, a sample with `inValid`=1 is accepted on every clock. A run of equal indices adds its length to that bin.
- R5: When the index changes on every cycle, every sample is still counted in its own bin.
- R6: A sample that returns to a bin whose count write has not yet reached the RAM (for example A,B,A) sees the pending count, and no increment is lost.
- R7: Cycles with `inValid`=0 inside a frame neither add counts nor lose them.
- R8: Let the clock edge that accepts the sample with `inLast`=1 be edge E0. Then `busy` is 1 in the two cycles that follow E0, and `done` is 1 for exactly one cycle, starting after edge E0+2.
- R9: A frame made of a single sample with `inLast`=1 adds one to that bin.
- R10: A frame that is not preceded by a clear adds its counts to the values already stored.
- R11: While the block is idle, `rdData` shows the count of the bin at `rdAddr` one clock edge after `rdAddr` is sampled.
- R12: Counts are ceil(log2(MAX_FRAME+1)) bits wide. A frame of MAX_FRAME identical samples reads back as MAX_FRAME.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clearReq | input | 1 | Request to zero all bins while idle |
| inValid | input | 1 | Sample present on `inBin` |
| inBin | input | BIN_W | Bin index of the sample |
| inLast | input | 1 | Marks the final sample of a frame |
| busy | output | 1 | Clearing or flushing; input is ignored |
| done | output | 1 | One-cycle pulse once the final count is stored |
| rdAddr | input | BIN_W | Bin to read while idle |
| rdData | output | ceil(log2(MAX_FRAME+1)) | Count of the bin addressed one cycle earlier |

## Verification
The bench targets returns to a bin whose write is still pending. A design that does not forward that write would read a stale count, and a bin visited A,B,A would end up one short. It sends runs, alternating indices, gaps in `inValid` and single-sample frames, which would expose an accumulator that is not folded back correctly; such a design would drop or double counts at run boundaries. It also pokes input during the clear and during the flush, checks the exact cycle of `done`, and checks that a frame without a clear accumulates. A design that reset the first bin's count instead of reading it would fail that last test.

// File: rtl/hist_run_pkg.sv
package hist_run_pkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic take;   // sample accepted this cycle
    logic first;  // accepted sample opens a frame
    logic flush;  // write the open run back to its bin
    logic clrWe;  // zero the bin at the clear address
  } histStrb_t;

endpackage

// File: rtl/hist_run_ctrl.sv
module hist_run_ctrl
  import hist_run_pkg::*;
#(
  parameter int BIN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clearReq,
  input  logic             inValid,
  input  logic             inLast,
  output histStrb_t        strb,
  output logic [BIN_W-1:0] clrAddr,
  output logic             busy,
  output logic             done
);

  localparam int NBINS = 1 << BIN_W;

  typedef enum logic [2:0] {
    S_IDLE, S_CLEAR, S_RUN, S_FLUSH, S_DRAIN
  } ctrlState_t;

  ctrlState_t state;
  logic [BIN_W-1:0] clrCnt;

  always_comb begin
    strb.take  = inValid && ((state == S_IDLE && !clearReq) || state == S_RUN);
    strb.first = strb.take && (state == S_IDLE);
    strb.flush = (state == S_FLUSH);
    strb.clrWe = (state == S_CLEAR);
  end

  assign clrAddr = clrCnt;
  assign busy    = (state == S_CLEAR) || (state == S_FLUSH) || (state == S_DRAIN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      clrCnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= (state == S_DRAIN);
      unique case (state)
        S_IDLE: begin
          if (clearReq) begin
            state  <= S_CLEAR;
            clrCnt <= '0;
          end else if (inValid) begin
            state <= inLast ? S_FLUSH : S_RUN;
          end
        end
        S_CLEAR: begin
          if (clrCnt == BIN_W'(NBINS - 1)) begin
            state  <= S_IDLE;
            clrCnt <= '0;
          end else begin
            clrCnt <= clrCnt + 1'b1;
          end
        end
        S_RUN:   if (inValid && inLast) state <= S_FLUSH;
        S_FLUSH: state <= S_DRAIN;
        S_DRAIN: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2
  clear_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && clearReq) |=> busy);

endmodule

// File: rtl/hist_run_dp.sv
module hist_run_dp
  import hist_run_pkg::*;
#(
  parameter int BIN_W = 4,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  histStrb_t        strb,
  input  logic [BIN_W-1:0] clrAddr,
  input  logic [BIN_W-1:0] inBin,
  input  logic [BIN_W-1:0] extAddr,
  output logic [CNT_W-1:0] rdData
);

  localparam int NBINS = 1 << BIN_W;

  logic [CNT_W-1:0] mem [NBINS];

  logic [BIN_W-1:0] prevIdx;
  logic [CNT_W-1:0] acc;
  logic             basePend;   // rdQ holds the stored base of the open run
  logic             wrValid;
  logic [BIN_W-1:0] wrAddr;
  logic [CNT_W-1:0] wrData;
  logic [CNT_W-1:0] rdQ;

  logic [BIN_W-1:0] rdAddrSel;
  logic [CNT_W-1:0] accEff;
  logic             sameBin;

  assign rdAddrSel = strb.take ? inBin : extAddr;
  assign accEff    = acc + (basePend ? rdQ : '0);
  assign sameBin   = (inBin == prevIdx);
  assign rdData    = rdQ;

  // Bin storage: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (strb.clrWe)
      mem[clrAddr] <= '0;
    else if (wrValid)
      mem[wrAddr] <= wrData;
  end

  // Read with bypass of the write staged for this edge
  always_ff @(posedge clk) begin
    if (!rstN)
      rdQ <= '0;
    else if (wrValid && !strb.clrWe && wrAddr == rdAddrSel)
      rdQ <= wrData;
    else
      rdQ <= mem[rdAddrSel];
  end

  // Run accumulator and write staging
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevIdx  <= '0;
      acc      <= '0;
      basePend <= 1'b0;
      wrValid  <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
    end else begin
      wrValid  <= 1'b0;
      basePend <= 1'b0;
      acc      <= accEff;
      if (strb.take) begin
        if (strb.first || !sameBin) begin
          if (!strb.first) begin
            wrValid <= 1'b1;
            wrAddr  <= prevIdx;
            wrData  <= accEff;
          end
          acc      <= CNT_W'(1);
          basePend <= 1'b1;
          prevIdx  <= inBin;
        end else begin
          acc <= accEff + CNT_W'(1);
        end
      end else if (strb.flush) begin
        wrValid <= 1'b1;
        wrAddr  <= prevIdx;
        wrData  <= accEff;
      end
    end
  end

  // R6
  ram_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wrValid) && !$past(strb.clrWe)) |-> (mem[$past(wrAddr)] == $past(wrData)));

  // R4
  acc_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |=> (acc != '0));

endmodule

// File: rtl/hist_run_engine.sv
module hist_run_engine
  import hist_run_pkg::*;
#(
  parameter int BIN_W     = 4,
  parameter int MAX_FRAME = 1000,
  localparam int CNT_W    = $clog2(MAX_FRAME + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clearReq,
  input  logic             inValid,
  input  logic [BIN_W-1:0] inBin,
  input  logic             inLast,
  output logic             busy,
  output logic             done,
  input  logic [BIN_W-1:0] rdAddr,
  output logic [CNT_W-1:0] rdData
);

  histStrb_t        strb;
  logic [BIN_W-1:0] clrAddr;

  hist_run_ctrl #(.BIN_W(BIN_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clearReq (clearReq),
    .inValid  (inValid),
    .inLast   (inLast),
    .strb     (strb),
    .clrAddr  (clrAddr),
    .busy     (busy),
    .done     (done)
  );

  hist_run_dp #(.BIN_W(BIN_W), .CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .clrAddr (clrAddr),
    .inBin   (inBin),
    .extAddr (rdAddr),
    .rdData  (rdData)
  );

  // R3
  busy_no_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.take);

endmodule

// File: tb/tb_hist_run_engine.sv
`timescale 1ns/1ps
module tb_hist_run_engine;

  localparam int BIN_W     = 4;
  localparam int MAX_FRAME = 1000;
  localparam int CNT_W     = $clog2(MAX_FRAME + 1);
  localparam int NBINS     = 1 << BIN_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             clearReq = 1'b0;
  logic             inValid = 1'b0;
  logic [BIN_W-1:0] inBin = '0;
  logic             inLast = 1'b0;
  logic             busy;
  logic             done;
  logic [BIN_W-1:0] rdAddr = '0;
  logic [CNT_W-1:0] rdData;

  int nChecks = 0;
  int nFails  = 0;
  int doneCnt = 0;
  int model [NBINS];
  int frameQ [$];

  always #4 clk = ~clk;

  hist_run_engine #(.BIN_W(BIN_W), .MAX_FRAME(MAX_FRAME)) dut (
    .clk(clk), .rstN(rstN), .clearReq(clearReq), .inValid(inValid),
    .inBin(inBin), .inLast(inLast), .busy(busy), .done(done),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  always @(negedge clk) if (rstN && done) doneCnt++;

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  // Read every bin through the read port and compare with the model (R11)
  task automatic checkBins(string req);
    for (int b = 0; b < NBINS; b++) begin
      @(negedge clk) rdAddr = BIN_W'(b);
      @(negedge clk);
      check({req, " R11 bin read"}, int'(rdData), model[b]);
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", int'(busy), 0);
    check("R1 done in reset", int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 done after reset", int'(done), 0);
  endtask

  // Clear; optionally poke inputs during it (R3)
  task automatic doClear(bit poke);
    int cnt = 0;
    int d0 = doneCnt;
    @(negedge clk) clearReq = 1'b1;
    @(negedge clk) clearReq = 1'b0;
    while (busy && cnt < 4 * NBINS) begin
      cnt++;
      if (poke && cnt == 1) begin
        inValid = 1'b1; inBin = 3; inLast = 1'b1;
      end
      if (cnt == 4) begin
        inValid = 1'b0; inLast = 1'b0;
      end
      @(negedge clk);
    end
    inValid = 1'b0; inLast = 1'b0;
    check("R2 clear busy cycles", cnt, NBINS);
    if (poke) check("R3 no done from input during clear", doneCnt - d0, 0);
    for (int b = 0; b < NBINS; b++) model[b] = 0;
    checkBins("R2 R3 bins after clear");
  endtask

  // Play frameQ (-1 = idle cycle); last entry must be a sample. Checks R8 and R3.
  task automatic playFrame(string req);
    int n = frameQ.size();
    int d0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (frameQ[i] < 0) begin
        inValid = 1'b0; inLast = 1'b0;
      end else begin
        inValid = 1'b1;
        inBin   = BIN_W'(frameQ[i]);
        inLast  = (i == n - 1);
        model[frameQ[i]]++;
      end
    end
    d0 = doneCnt;
    @(negedge clk);
    check({req, " R8 busy in flush"}, int'(busy), 1);
    check({req, " R8 done early"}, int'(done), 0);
    inValid = 1'b1; inBin = 5; inLast = 1'b0;   // ignored: R3
    @(negedge clk);
    inValid = 1'b0;
    check({req, " R8 busy in drain"}, int'(busy), 1);
    check({req, " R8 done early"}, int'(done), 0);
    @(negedge clk);
    check({req, " R8 done pulse"}, int'(done), 1);
    check({req, " R8 idle at done"}, int'(busy), 0);
    @(negedge clk);
    check({req, " R8 done one cycle"}, int'(done), 0);
    check({req, " R8 single done"}, doneCnt - d0, 1);
    frameQ.delete();
  endtask

  task automatic testRuns();
    frameQ = '{2, 2, 2, 5, 5, 9, 9, 9, 9, 0};
    playFrame("R4 runs");
    checkBins("R4 runs");
  endtask

  task automatic testAlternate();
    doClear(1'b0);
    frameQ = '{1, 2, 3, 4, 5, 6, 7, 8, 15, 14, 0, 13};
    playFrame("R5 alternating");
    checkBins("R5 alternating");
  endtask

  task automatic testReturn();
    doClear(1'b0);
    frameQ = '{6, 7, 6, 7, 6, 8, 9, 8, 8, 9, 6};
    playFrame("R6 return to pending bin");
    checkBins("R6 return to pending bin");
  endtask

  task automatic testGaps();
    doClear(1'b0);
    frameQ = '{4, -1, 4, -1, -1, 10, -1, 4, 4, -1, 10};
    playFrame("R7 gaps");
    checkBins("R7 gaps");
  endtask

  task automatic testSingle();
    doClear(1'b0);
    frameQ = '{12};
    playFrame("R9 single sample");
    checkBins("R9 single sample");
  endtask

  task automatic testAccumulate();
    frameQ = '{12, 12, 3, 12, 1};
    playFrame("R10 no clear");
    checkBins("R10 no clear");
  endtask

  task automatic testLong();
    doClear(1'b0);
    for (int i = 0; i < MAX_FRAME; i++) frameQ.push_back(7);
    playFrame("R12 max frame");
    checkBins("R12 max frame");
  endtask

  initial begin
    for (int b = 0; b < NBINS; b++) model[b] = 0;
    testReset();
    doClear(1'b1);
    testRuns();
    testAlternate();
    testReturn();
    testGaps();
    testSingle();
    testAccumulate();
    testLong();
    summary();
    $finish;
  end

endmodule